// File: doc/BRIEF.md
# Double-Data-Rate Video Output Formatter

This block sits between an internal display pipeline and an external digital video transmitter or panel. Each pixel clock it takes a 24-bit pixel and a set of raster flags: horizontal sync, vertical sync, an inner active window and a wider window that includes the border. It drives a 12-bit bus at twice the pixel rate: one half of the word follows the rising edge of the forwarded clock and the other half follows the falling edge. The forwarded clock leaves the block as a true/complement pair. Sync polarities are programmable. A single active-indication output can mark either the inner window or the bordered window.

One auxiliary input serves two purposes. In field mode it reports the current field of an external TV encoder, so that interleaved overlay output can follow that field. In stall mode it is a panel request. The block then takes the upstream ready line low for exactly one whole line, starting at the next line boundary. The input has its own polarity bit and can be switched off.

All configuration is held in a shadow copy that loads only while the pipeline flags vertical blanking. A change made in the middle of a frame therefore waits for the next blanking interval.

Top module: `dvo_port_fmt`

## Requirements
- R1: The output word register holds the pixel. While `dvo_clk_p` is high, `dvo_data` shows bits [11:0] of that word. While it is low, `dvo_data` shows bits [23:12].
- R2: Pixel data, both syncs and the active indication all reach the port with the same latency. Inputs sampled at one rising edge appear after the following rising edge.
- R3: `dvo_clk_p` is in phase with the pixel clock, and `dvo_clk_n` is always its complement.
- R4: `dvo_hs` equals the internal horizontal sync XOR the effective `cfg_hs_inv`. `dvo_vs` equals the internal vertical sync XOR the effective `cfg_vs_inv`. A value of 1 in either bit gives an active-low output. The two bits act independently.
- R5: When the effective `cfg_border` is 0, `dvo_act` follows `pix_de` (inner window). When it is 1, `dvo_act` follows `pix_bde` (window including border).
- R6: The effective configuration loads from the configuration inputs only at rising edges where `frame_vblank` is 1. Changes made while it is 0 have no effect on any output.
- R7: When the effective `cfg_aux_en` is 0, `field_out` stays 0 and `pipe_ready` stays 1 whatever `aux_in` does.
- R8: When the auxiliary input is enabled and `cfg_aux_stall` is 0 (field mode), `field_out` equals `aux_in` XOR `cfg_aux_inv`. The value appears two rising edges after the edge that first samples `aux_in`. Field mode never lowers `pipe_ready`.
- R9: In stall mode (`cfg_aux_en` = 1, `cfg_aux_stall` = 1), a request is `aux_in` XOR `cfg_aux_inv` equal to 1. A request sampled at least three rising edges before a rising edge of `pix_hs` drives `pipe_ready` low from that edge of `pix_hs` onward, for exactly one line. `pipe_ready` returns high at the following rising edge of `pix_hs` unless a new request is pending.
- R10: With `cfg_aux_inv` = 1, a low level on `aux_in` is the request or field-high level, and a high level is idle.
- R11: During reset, `dvo_data`, `dvo_hs`, `dvo_vs`, `dvo_act` and `field_out` are 0, `pipe_ready` is 1, and the effective configuration is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_data | input | 24 | Pixel word from the pipeline |
| pix_hs | input | 1 | Internal horizontal sync, active high |
| pix_vs | input | 1 | Internal vertical sync, active high |
| pix_de | input | 1 | Inner active window |
| pix_bde | input | 1 | Active window including border |
| frame_vblank | input | 1 | Vertical blanking; configuration loads while high |
| cfg_hs_inv | input | 1 | Invert horizontal sync at the port |
| cfg_vs_inv | input | 1 | Invert vertical sync at the port |
| cfg_border | input | 1 | 1 selects the bordered window for `dvo_act` |
| cfg_aux_en | input | 1 | Enable the auxiliary input |
| cfg_aux_stall | input | 1 | 1 stall mode, 0 field mode |
| cfg_aux_inv | input | 1 | Invert the auxiliary input |
| aux_in | input | 1 | Asynchronous field or stall input |
| pipe_ready | output | 1 | Upstream ready; low during a stalled line |
| field_out | output | 1 | Synchronised encoder field |
| dvo_clk_p | output | 1 | Forwarded clock, true |
| dvo_clk_n | output | 1 | Forwarded clock, complement |
| dvo_data | output | 12 | Double-data-rate pixel bus |
| dvo_hs | output | 1 | Port horizontal sync |
| dvo_vs | output | 1 | Port vertical sync |
| dvo_act | output | 1 | Blank or border indication |

## Verification
Two events can fall on the same rising edge: the load of a new shadow configuration during blanking, and a line boundary that either starts a stall or clears one. A third can join them in the same cycle, when the auxiliary input changes level because its polarity changed. The bench sweeps frames through every combination of sync polarities, window mode and auxiliary polarity, under the disabled, field and stall variants. Each frame changes its mode in blanking lines whose hsync edges coincide with configuration loads. Each frame also drives contradictory configuration in the middle of the frame, where it must be ignored. Every port output is judged every half cycle against a model built from the stated latencies. The ready line is judged against whole-line stall windows derived from where the request pulses were placed.

// File: rtl/dvo_fmt_pkg.sv
`timescale 1ns/1ps
package dvo_fmt_pkg;

   // Effective configuration of the output formatter
   typedef struct packed {
      logic hs_inv;
      logic vs_inv;
      logic border_mode;
      logic aux_en;
      logic aux_stall;
      logic aux_inv;
   } dvo_cfg_t;

   localparam dvo_cfg_t DVO_CFG_RESET = '0;

endpackage

// File: rtl/dvo_cfg_shadow.sv
`timescale 1ns/1ps
module dvo_cfg_shadow
   import dvo_fmt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load_en,
   input  dvo_cfg_t cfg_in,
   output dvo_cfg_t cfg_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q <= DVO_CFG_RESET;
      else if (load_en) cfg_q <= cfg_in;
   end

   // R6: outside blanking the shadow copy must not move
   p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(cfg_q));

endmodule

// File: rtl/dvo_aux_ctrl.sv
`timescale 1ns/1ps
module dvo_aux_ctrl
   import dvo_fmt_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     aux_in,
   input  logic     line_hs,
   input  dvo_cfg_t cfg,
   output logic     field_out,
   output logic     stall_out
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $fatal(1, "dvo_aux_ctrl: SYNC_STAGES must be at least 2");
   end

   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   hs_prev_q;
   logic                   pending_q;
   logic                   stall_q;
   logic                   field_q;
   logic                   aux_lvl;
   logic                   stall_mode;
   logic                   field_mode;
   logic                   stall_req;
   logic                   hs_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[LAST-1:0], aux_in};
   end

   always_comb begin
      aux_lvl    = sync_q[LAST] ^ cfg.aux_inv;
      stall_mode = cfg.aux_en & cfg.aux_stall;
      field_mode = cfg.aux_en & ~cfg.aux_stall;
      stall_req  = stall_mode & aux_lvl;
      hs_rise    = line_hs & ~hs_prev_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_prev_q <= 1'b0;
         pending_q <= 1'b0;
         stall_q   <= 1'b0;
         field_q   <= 1'b0;
      end else begin
         hs_prev_q <= line_hs;
         pending_q <= stall_req | (pending_q & ~hs_rise);
         if (hs_rise) stall_q <= pending_q & stall_mode;
         field_q   <= field_mode ? aux_lvl : 1'b0;
      end
   end

   assign field_out = field_q;
   assign stall_out = stall_q;

   // R7: a disabled input yields no field indication
   p_field_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.aux_en |=> !field_out);

   // R9: a stall only begins on a line boundary
   p_stall_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !stall_out && !hs_rise |=> !stall_out);

   // R9: a running stall lasts until the next line boundary
   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall_out && !hs_rise |=> stall_out);

endmodule

// File: rtl/dvo_ddr_out.sv
`timescale 1ns/1ps
module dvo_ddr_out
   import dvo_fmt_pkg::*;
#(
   parameter int DATA_W      = 24,
   parameter bit LOW_ON_RISE = 1'b1,
   localparam int HALF_W     = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pix_data,
   input  logic              pix_hs,
   input  logic              pix_vs,
   input  logic              pix_de,
   input  logic              pix_bde,
   input  dvo_cfg_t          cfg,
   output logic [HALF_W-1:0] dvo_data,
   output logic              dvo_clk_p,
   output logic              dvo_clk_n,
   output logic              dvo_hs,
   output logic              dvo_vs,
   output logic              dvo_act
);

   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
      initial $fatal(1, "dvo_ddr_out: DATA_W must be even and at least 2");
   end

   // stage 1: capture
   logic [DATA_W-1:0] s1_data_q;
   logic              s1_hs_q;
   logic              s1_vs_q;
   logic              s1_de_q;
   logic              s1_bde_q;
   // stage 2: port register
   logic [DATA_W-1:0] word_q;
   logic              hs_q;
   logic              vs_q;
   logic              act_q;
   logic [HALF_W-1:0] rise_half;
   logic [HALF_W-1:0] fall_half;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_data_q <= '0;
         s1_hs_q   <= 1'b0;
         s1_vs_q   <= 1'b0;
         s1_de_q   <= 1'b0;
         s1_bde_q  <= 1'b0;
      end else begin
         s1_data_q <= pix_data;
         s1_hs_q   <= pix_hs;
         s1_vs_q   <= pix_vs;
         s1_de_q   <= pix_de;
         s1_bde_q  <= pix_bde;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         hs_q   <= 1'b0;
         vs_q   <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         word_q <= s1_data_q;
         hs_q   <= s1_hs_q ^ cfg.hs_inv;
         vs_q   <= s1_vs_q ^ cfg.vs_inv;
         act_q  <= cfg.border_mode ? s1_bde_q : s1_de_q;
      end
   end

   if (LOW_ON_RISE) begin : g_low_first
      assign rise_half = word_q[HALF_W-1:0];
      assign fall_half = word_q[DATA_W-1:HALF_W];
   end else begin : g_high_first
      assign rise_half = word_q[DATA_W-1:HALF_W];
      assign fall_half = word_q[HALF_W-1:0];
   end

   // behavioural model of the output register pair feeding the pads
   assign dvo_data  = clk ? rise_half : fall_half;
   assign dvo_clk_p = clk;
   assign dvo_clk_n = ~clk;
   assign dvo_hs    = hs_q;
   assign dvo_vs    = vs_q;
   assign dvo_act   = act_q;

endmodule

// File: rtl/dvo_port_fmt.sv
`timescale 1ns/1ps
module dvo_port_fmt
   import dvo_fmt_pkg::*;
#(
   parameter int DATA_W      = 24,
   parameter int SYNC_STAGES = 2,
   parameter bit LOW_ON_RISE = 1'b1,
   localparam int HALF_W     = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pix_data,
   input  logic              pix_hs,
   input  logic              pix_vs,
   input  logic              pix_de,
   input  logic              pix_bde,
   input  logic              frame_vblank,
   input  logic              cfg_hs_inv,
   input  logic              cfg_vs_inv,
   input  logic              cfg_border,
   input  logic              cfg_aux_en,
   input  logic              cfg_aux_stall,
   input  logic              cfg_aux_inv,
   input  logic              aux_in,
   output logic              pipe_ready,
   output logic              field_out,
   output logic              dvo_clk_p,
   output logic              dvo_clk_n,
   output logic [HALF_W-1:0] dvo_data,
   output logic              dvo_hs,
   output logic              dvo_vs,
   output logic              dvo_act
);

   dvo_cfg_t cfg_in;
   dvo_cfg_t cfg_q;
   logic     stall;

   always_comb begin
      cfg_in.hs_inv      = cfg_hs_inv;
      cfg_in.vs_inv      = cfg_vs_inv;
      cfg_in.border_mode = cfg_border;
      cfg_in.aux_en      = cfg_aux_en;
      cfg_in.aux_stall   = cfg_aux_stall;
      cfg_in.aux_inv     = cfg_aux_inv;
   end

   dvo_cfg_shadow u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (frame_vblank),
      .cfg_in  (cfg_in),
      .cfg_q   (cfg_q)
   );

   dvo_aux_ctrl #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_aux (
      .clk       (clk),
      .rst_n     (rst_n),
      .aux_in    (aux_in),
      .line_hs   (pix_hs),
      .cfg       (cfg_q),
      .field_out (field_out),
      .stall_out (stall)
   );

   dvo_ddr_out #(
      .DATA_W      (DATA_W),
      .LOW_ON_RISE (LOW_ON_RISE)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_data  (pix_data),
      .pix_hs    (pix_hs),
      .pix_vs    (pix_vs),
      .pix_de    (pix_de),
      .pix_bde   (pix_bde),
      .cfg       (cfg_q),
      .dvo_data  (dvo_data),
      .dvo_clk_p (dvo_clk_p),
      .dvo_clk_n (dvo_clk_n),
      .dvo_hs    (dvo_hs),
      .dvo_vs    (dvo_vs),
      .dvo_act   (dvo_act)
   );

   assign pipe_ready = ~stall;

   // cycles since reset, saturating, so that $past never reaches into reset
   logic [1:0] warm_q;
   logic       hs_inv_q;
   logic       vs_inv_q;
   logic       border_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            warm_q <= '0;
      else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
   end

   assign hs_inv_q = cfg_q.hs_inv;
   assign vs_inv_q = cfg_q.vs_inv;
   assign border_q = cfg_q.border_mode;

   // R2, R4: sync latency and polarity at the port
   p_hs_pol_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd2) |-> (dvo_hs == ($past(pix_hs, 2) ^ $past(hs_inv_q))));
   p_vs_pol_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd2) |-> (dvo_vs == ($past(pix_vs, 2) ^ $past(vs_inv_q))));
   // R5: window selection
   p_act_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd2) |-> (dvo_act == ($past(border_q) ? $past(pix_bde, 2) : $past(pix_de, 2))));
   // R3: complementary forwarded clock
   always_comb begin
      if (rst_n) p_clk_pair_r3: assert (dvo_clk_n == ~dvo_clk_p);
   end

endmodule

// File: tb/dvo_port_fmt_tb.sv
`timescale 1ns/1ps
module dvo_port_fmt_tb;

   localparam int LINE    = 16;
   localparam int LINES   = 8;
   localparam int NFRAMES = 48;
   localparam int NCYC    = LINE * LINES * NFRAMES;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] pix_data = '0;
   logic        pix_hs = 0, pix_vs = 0, pix_de = 0, pix_bde = 0, frame_vblank = 0;
   logic        cfg_hs_inv = 0, cfg_vs_inv = 0, cfg_border = 0;
   logic        cfg_aux_en = 0, cfg_aux_stall = 0, cfg_aux_inv = 0;
   logic        aux_in = 0;
   logic        pipe_ready, field_out, dvo_clk_p, dvo_clk_n;
   logic [11:0] dvo_data;
   logic        dvo_hs, dvo_vs, dvo_act;

   always #2.5 clk = ~clk;

   dvo_port_fmt u_dut (
      .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .pix_hs(pix_hs), .pix_vs(pix_vs),
      .pix_de(pix_de), .pix_bde(pix_bde), .frame_vblank(frame_vblank),
      .cfg_hs_inv(cfg_hs_inv), .cfg_vs_inv(cfg_vs_inv), .cfg_border(cfg_border),
      .cfg_aux_en(cfg_aux_en), .cfg_aux_stall(cfg_aux_stall), .cfg_aux_inv(cfg_aux_inv),
      .aux_in(aux_in), .pipe_ready(pipe_ready), .field_out(field_out),
      .dvo_clk_p(dvo_clk_p), .dvo_clk_n(dvo_clk_n), .dvo_data(dvo_data),
      .dvo_hs(dvo_hs), .dvo_vs(dvo_vs), .dvo_act(dvo_act)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // expected-value rings indexed by drive cycle
   logic [23:0] r_d   [8];
   logic        r_hs  [8];
   logic        r_vs  [8];
   logic        r_act [8];
   logic        r_fld [8];
   logic        r_rdy [8];
   int          r_ln  [8];
   int          r_var [8];

   // bench view of the effective configuration
   logic e_hs = 0, e_vs = 0, e_bd = 0, e_en = 0, e_st = 0, e_inv = 0;
   logic n_hs, n_vs, n_bd, n_en, n_st, n_inv;
   logic old_inv = 0, aux_prev = 0, stall_flag = 0, line_low = 0;
   int   pos, ln, fr, v;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      // R11 reset state
      chk("R11", "data", 32'(dvo_data), 0);
      chk("R11", "hs", 32'(dvo_hs), 0);
      chk("R11", "vs", 32'(dvo_vs), 0);
      chk("R11", "act", 32'(dvo_act), 0);
      chk("R11", "field", 32'(field_out), 0);
      chk("R11", "ready", 32'(pipe_ready), 1);
      @(negedge clk);
      rst_n = 1'b1;

      for (int c = 0; c < NCYC; c++) begin
         @(negedge clk);
         pos = c % LINE;
         ln  = (c / LINE) % LINES;
         fr  = c / (LINE * LINES);
         v   = fr / 16;
         n_hs = fr[0]; n_vs = fr[1]; n_bd = fr[2]; n_inv = fr[3];
         n_en = (v != 0); n_st = (v == 2);

         // configuration: mode switch with aux off in line 0, junk mid-frame (R6)
         if (ln == 0) {cfg_hs_inv, cfg_vs_inv, cfg_border, cfg_aux_en, cfg_aux_stall, cfg_aux_inv} = {n_hs, n_vs, n_bd, 1'b0, n_st, n_inv};
         else if (ln == 5) {cfg_hs_inv, cfg_vs_inv, cfg_border, cfg_aux_en, cfg_aux_stall, cfg_aux_inv} = ~{n_hs, n_vs, n_bd, n_en, n_st, n_inv};
         else {cfg_hs_inv, cfg_vs_inv, cfg_border, cfg_aux_en, cfg_aux_stall, cfg_aux_inv} = {n_hs, n_vs, n_bd, n_en, n_st, n_inv};
         frame_vblank = (ln <= 2);

         // auxiliary input: idle at the inactive level, pulses on lines 4 and 6
         if (ln == 0 && pos < 4) aux_in = old_inv;
         else aux_in = n_inv;
         if ((ln == 4 || ln == 6) && (pos == 6 || pos == 7)) aux_in = ~n_inv;
         if (ln == 0 && pos == LINE - 1) old_inv = n_inv;

         // raster
         pix_hs  = (pos < 2);
         pix_vs  = (ln < 2);
         pix_bde = (ln >= 3) && (pos >= 3) && (pos <= 14);
         pix_de  = (ln >= 3) && (pos >= 4) && (pos <= 13);
         pix_data = 24'((c * 32'h9E3779B1) ^ (c << 5));

         if (frame_vblank) {e_hs, e_vs, e_bd, e_en, e_st, e_inv} = {cfg_hs_inv, cfg_vs_inv, cfg_border, cfg_aux_en, cfg_aux_stall, cfg_aux_inv};

         r_d[c % 8]   = pix_data;
         r_hs[c % 8]  = pix_hs ^ e_hs;
         r_vs[c % 8]  = pix_vs ^ e_vs;
         r_act[c % 8] = e_bd ? pix_bde : pix_de;
         r_ln[c % 8]  = ln;
         r_var[c % 8] = v;
         r_fld[(c + 1) % 8] = (e_en && !e_st) ? (aux_prev ^ e_inv) : 1'b0;
         aux_prev = aux_in;

         if (pos == 0) begin
            line_low   = stall_flag;
            stall_flag = 1'b0;
         end
         if (e_en && e_st && ((aux_in ^ e_inv) == 1'b1)) stall_flag = 1'b1;
         r_rdy[c % 8] = ~line_low;

         #1;
         if (c >= 2) begin
            chk("R1", "upper half", 32'(dvo_data), 32'(r_d[(c - 2) % 8][23:12]));
            chk("R3", "clk pair low", 32'({dvo_clk_p, dvo_clk_n}), 32'h1);
         end

         @(posedge clk);
         #1;
         chk("R3", "clk pair high", 32'({dvo_clk_p, dvo_clk_n}), 32'h2);
         if (c >= 1) begin
            chk("R1", "lower half", 32'(dvo_data), 32'(r_d[(c - 1) % 8][11:0]));
            if (r_ln[(c - 1) % 8] == 5) begin
               chk("R6", "hs", 32'(dvo_hs), 32'(r_hs[(c - 1) % 8]));
               chk("R6", "act", 32'(dvo_act), 32'(r_act[(c - 1) % 8]));
            end else begin
               chk("R4", "hs", 32'(dvo_hs), 32'(r_hs[(c - 1) % 8]));
               chk("R2", "act", 32'(dvo_act), 32'(r_act[(c - 1) % 8]));
               chk("R5", "act", 32'(dvo_act), 32'(r_act[(c - 1) % 8]));
            end
            chk("R4", "vs", 32'(dvo_vs), 32'(r_vs[(c - 1) % 8]));
         end
         if (c >= 2) begin
            if (r_var[c % 8] == 1) chk(e_inv ? "R10" : "R8", "field", 32'(field_out), 32'(r_fld[c % 8]));
            else                   chk("R7", "field", 32'(field_out), 32'(r_fld[c % 8]));
         end
         if (r_var[c % 8] == 2) chk(e_inv ? "R10" : "R9", "ready", 32'(pipe_ready), 32'(r_rdy[c % 8]));
         else                   chk("R7", "ready", 32'(pipe_ready), 32'(r_rdy[c % 8]));
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule